// File: doc/BRIEF.md
# Shared RAM Ownership Arbiter

This block owns a small set of RAM banks that a host processor and a coprocessor share. Ownership of each bank changes at runtime. After reset every bank belongs to the host. A configuration write can later hand one designated bank to the coprocessor as instruction storage, or hand any bank to the coprocessor as data storage. The block steers four requesters to the banks according to each bank's current mode. The requesters are a host port, a coprocessor data port, a coprocessor fetch port and a debug port.

Every access completes in the cycle it is presented. Read data comes back combinationally, and writes land at the following clock edge. Each bank has a three-state ownership machine with these states:
- `M_HOST`: the host owns the bank.
- `M_PROG`: the bank holds coprocessor instructions.
- `M_DATA`: the bank holds coprocessor data.

On a configuration write each bank takes one of these transitions, from any state:
- **to_prog**: the program-enable bit is set and this is the designated program bank.
- **to_data**: the bank's data-enable bit is set and to_prog does not apply.
- **to_host**: neither enable bit applies.

With no configuration write, the machine holds its state.

Top module: `srm_arbiter`

## Requirements
- R1: After reset all banks are in host mode. Host reads return the stored word, and host writes (h_we=1, h_fetch=0) are stored, with h_ready=1 and h_viol=0. A host fetch (h_fetch=1) reads like a plain read.
- R2: The configuration word has four fields:
  - bit 0 is program-enable, which moves bank 0 to program mode.
  - bits 1+i are data-enable, which moves bank i to data mode.
  - bits 3+i are host-fetch-protect.
  - bits 5+i are host-write-protect.
  Program-enable takes precedence over data-enable for bank 0. A bank with neither enable bit set returns to host mode.
- R3: A configuration write takes effect on the cycle after it is presented. An access presented in the same cycle as the write uses the old mapping.
- R4: While bank 0 is in program mode, a debug access to it gets d_ready=1 only in a cycle with f_req low. In that case the read returns the stored word and a write is stored.
- R5: Fetch behaviour depends on the fetch address and the mode of bank 0:
  - An even fetch address with bank 0 in program mode gives f_valid=1 and f_rdata = {word[a+1], word[a]}.
  - An odd fetch address gives f_misalign=1, f_valid=0 and f_rdata=0.
  - An even address with bank 0 not in program mode gives neither flag.
- R6: A host access to a program-mode bank gets h_ready=1, h_viol=1 and h_rdata=0, and any write is dropped.
- R7: In data mode, when the host and the coprocessor address the same bank in one cycle, the coprocessor is served and h_ready=0. When they address different banks, both are served.
- R8: In data mode, host-fetch-protect refuses host fetches (h_viol=1, h_rdata=0), and host-write-protect refuses and drops host writes. Each protection bit leaves the other kind of access unaffected.
- R9: A coprocessor data access to a bank not in data mode returns c_rdata=0, and any write is dropped.
- R10: A debug access to a bank in host or data mode gets d_ready=1 only when neither the host nor the coprocessor data port addresses that bank in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word (fields in R2) |
| h_req | input | 1 | Host request |
| h_we | input | 1 | Host write |
| h_fetch | input | 1 | Host instruction fetch (read) |
| h_addr | input | 4 | Host address {bank, word} |
| h_wdata | input | 16 | Host write data |
| h_ready | output | 1 | Host access accepted this cycle |
| h_rdata | output | 16 | Host read data |
| h_viol | output | 1 | Host access refused |
| c_req | input | 1 | Coprocessor data request |
| c_we | input | 1 | Coprocessor data write |
| c_addr | input | 4 | Coprocessor data address {bank, word} |
| c_wdata | input | 16 | Coprocessor write data |
| c_rdata | output | 16 | Coprocessor read data |
| f_req | input | 1 | Coprocessor fetch request |
| f_addr | input | 3 | Fetch word address in bank 0 |
| f_valid | output | 1 | Fetch data valid |
| f_misalign | output | 1 | Odd fetch address |
| f_rdata | output | 32 | Fetched instruction |
| d_req | input | 1 | Debug request |
| d_we | input | 1 | Debug write |
| d_addr | input | 4 | Debug address {bank, word} |
| d_wdata | input | 16 | Debug write data |
| d_ready | output | 1 | Debug access granted |
| d_rdata | output | 16 | Debug read data |

## Verification
The bench sweeps every address in host mode and every fetch address in program mode, with a debug request colliding with each fetch. A debug gate that ignored the fetch would grant the debug access during those fetches. A fetch path that used the raw address for the upper word would return the wrong instruction. An odd address that slipped through would raise f_valid.

Each protection bit is tested alone, so swapping the fetch and write protection bits would show up at once. The bench also issues a host access in the same cycle as a configuration write, which catches a mapping that changes too early. Finally, every data-mode bank address is hit by simultaneous host and coprocessor requests. That exposes a wrong winner or a host write that slips past the stall.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic [1:0] {
        M_HOST = 2'd0,
        M_PROG = 2'd1,
        M_DATA = 2'd2
    } mode_t;
endpackage

// File: rtl/srm_mode_fsm.sv
module srm_mode_fsm
    import srm_pkg::*;
#(
    parameter bit IS_PROG = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cfg_we,
    input  logic  prog_en,
    input  logic  data_en,
    output mode_t mode
);
    mode_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= M_HOST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            unique case (state_q)
                M_HOST, M_PROG, M_DATA: begin
                    if (IS_PROG && prog_en) state_d = M_PROG;   // to_prog
                    else if (data_en)       state_d = M_DATA;   // to_data
                    else                    state_d = M_HOST;   // to_host
                end
                default: state_d = M_HOST;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            M_PROG:  mode = M_PROG;
            M_DATA:  mode = M_DATA;
            default: mode = M_HOST;
        endcase
    end
endmodule

// File: rtl/srm_bank.sv
module srm_bank #(
    parameter int AW = 3,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [DW-1:0]             wdata,
    output logic [DEPTH-1:0][DW-1:0]  q
);
    logic [DEPTH-1:0][DW-1:0] mem;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign q = mem;
endmodule

// File: rtl/srm_arbiter.sv
module srm_arbiter
    import srm_pkg::*;
#(
    parameter int NBLK     = 2,
    parameter int AW       = 3,
    parameter int DW       = 16,
    parameter int PROG_BLK = 0,
    localparam int BW    = $clog2(NBLK),
    localparam int XW    = BW + AW,
    localparam int CFGW  = 1 + 3 * NBLK,
    localparam int DEPTH = 1 << AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CFGW-1:0] cfg_wdata,
    input  logic            h_req,
    input  logic            h_we,
    input  logic            h_fetch,
    input  logic [XW-1:0]   h_addr,
    input  logic [DW-1:0]   h_wdata,
    output logic            h_ready,
    output logic [DW-1:0]   h_rdata,
    output logic            h_viol,
    input  logic            c_req,
    input  logic            c_we,
    input  logic [XW-1:0]   c_addr,
    input  logic [DW-1:0]   c_wdata,
    output logic [DW-1:0]   c_rdata,
    input  logic            f_req,
    input  logic [AW-1:0]   f_addr,
    output logic            f_valid,
    output logic            f_misalign,
    output logic [2*DW-1:0] f_rdata,
    input  logic            d_req,
    input  logic            d_we,
    input  logic [XW-1:0]   d_addr,
    input  logic [DW-1:0]   d_wdata,
    output logic            d_ready,
    output logic [DW-1:0]   d_rdata
);
    mode_t [NBLK-1:0]         mode_q;
    logic  [NBLK-1:0]         fprot_q, wprot_q;
    logic  [DEPTH-1:0][DW-1:0] bank_q [NBLK];

    logic [BW-1:0] h_blk, c_blk, d_blk;
    logic [AW-1:0] h_word, c_word, d_word;
    logic          host_wr, cop_wr, dbg_wr, dbg_busy;

    assign h_blk  = h_addr[AW +: BW];
    assign c_blk  = c_addr[AW +: BW];
    assign d_blk  = d_addr[AW +: BW];
    assign h_word = h_addr[AW-1:0];
    assign c_word = c_addr[AW-1:0];
    assign d_word = d_addr[AW-1:0];

    // protection bits are captured with the ownership state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fprot_q <= '0;
            wprot_q <= '0;
        end else if (cfg_we) begin
            fprot_q <= cfg_wdata[1+NBLK +: NBLK];
            wprot_q <= cfg_wdata[1+2*NBLK +: NBLK];
        end
    end

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic          we_g;
        logic [AW-1:0] wa_g;
        logic [DW-1:0] wd_g;

        srm_mode_fsm #(.IS_PROG(g == PROG_BLK)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (cfg_we),
            .prog_en (cfg_wdata[0]),
            .data_en (cfg_wdata[1+g]),
            .mode    (mode_q[g])
        );

        always_comb begin
            we_g = 1'b0;
            wa_g = '0;
            wd_g = '0;
            if (cop_wr && c_blk == BW'(g)) begin
                we_g = 1'b1; wa_g = c_word; wd_g = c_wdata;
            end else if (host_wr && h_blk == BW'(g)) begin
                we_g = 1'b1; wa_g = h_word; wd_g = h_wdata;
            end else if (dbg_wr && d_blk == BW'(g)) begin
                we_g = 1'b1; wa_g = d_word; wd_g = d_wdata;
            end
        end

        srm_bank #(.AW(AW), .DW(DW)) u_bank (
            .clk   (clk),
            .we    (we_g),
            .waddr (wa_g),
            .wdata (wd_g),
            .q     (bank_q[g])
        );
    end

    // host port
    always_comb begin
        h_ready = 1'b1;
        h_viol  = 1'b0;
        h_rdata = '0;
        host_wr = 1'b0;
        if (h_req) begin
            unique case (mode_q[h_blk])
                M_HOST: begin
                    h_rdata = bank_q[h_blk][h_word];
                    host_wr = h_we && !h_fetch;
                end
                M_PROG: h_viol = 1'b1;
                M_DATA: begin
                    if (c_req && c_blk == h_blk) begin
                        h_ready = 1'b0;
                    end else if ((h_fetch && fprot_q[h_blk]) ||
                                 (h_we && !h_fetch && wprot_q[h_blk])) begin
                        h_viol = 1'b1;
                    end else begin
                        h_rdata = bank_q[h_blk][h_word];
                        host_wr = h_we && !h_fetch;
                    end
                end
                default: h_viol = 1'b1;
            endcase
        end
    end

    // coprocessor data port
    always_comb begin
        c_rdata = '0;
        cop_wr  = 1'b0;
        if (c_req && mode_q[c_blk] == M_DATA) begin
            c_rdata = bank_q[c_blk][c_word];
            cop_wr  = c_we;
        end
    end

    // coprocessor fetch port
    always_comb begin
        f_valid    = 1'b0;
        f_misalign = 1'b0;
        f_rdata    = '0;
        if (f_req) begin
            if (f_addr[0]) begin
                f_misalign = 1'b1;
            end else if (mode_q[PROG_BLK] == M_PROG) begin
                f_valid = 1'b1;
                f_rdata = {bank_q[PROG_BLK][{f_addr[AW-1:1], 1'b1}],
                           bank_q[PROG_BLK][f_addr]};
            end
        end
    end

    // debug port: lowest priority on every bank
    always_comb begin
        if (mode_q[d_blk] == M_PROG)
            dbg_busy = f_req;
        else
            dbg_busy = (h_req && h_blk == d_blk) || (c_req && c_blk == d_blk);
        d_ready = !dbg_busy;
        dbg_wr  = d_req && d_we && !dbg_busy;
        d_rdata = (d_req && !dbg_busy) ? bank_q[d_blk][d_word] : '0;
    end
endmodule

// File: rtl/srm_checker.sv
module srm_checker
    import srm_pkg::*;
#(
    parameter int NBLK = 2,
    parameter int AW   = 3,
    parameter int DW   = 16,
    localparam int BW  = $clog2(NBLK),
    localparam int XW  = BW + AW,
    localparam int CFGW = 1 + 3 * NBLK
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFGW-1:0]  cfg_wdata,
    input mode_t [NBLK-1:0] mode_q,
    input logic             h_req,
    input logic [XW-1:0]    h_addr,
    input logic             h_ready,
    input logic             h_viol,
    input logic [DW-1:0]    h_rdata,
    input logic             c_req,
    input logic [XW-1:0]    c_addr,
    input logic             f_req,
    input logic [AW-1:0]    f_addr,
    input logic             f_valid,
    input logic             f_misalign,
    input logic             d_req,
    input logic [XW-1:0]    d_addr,
    input logic             d_ready
);
    logic [BW-1:0] hb, cb, db;
    assign hb = h_addr[AW +: BW];
    assign cb = c_addr[AW +: BW];
    assign db = d_addr[AW +: BW];

    a_r1_host_free: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && mode_q[hb] == M_HOST |-> h_ready && !h_viol);

    a_r3_prog_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[0] |=> mode_q[0] == M_PROG);

    a_r4_dbg_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        d_req && mode_q[db] == M_PROG && f_req |-> !d_ready);

    a_r4_dbg_free: assert property (@(posedge clk) disable iff (!rst_n)
        d_req && mode_q[db] == M_PROG && !f_req |-> d_ready);

    a_r5_odd_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        f_req && f_addr[0] |-> f_misalign && !f_valid);

    a_r6_prog_refused: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && mode_q[hb] == M_PROG |-> h_ready && h_viol && h_rdata == '0);

    a_r7_host_stall: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && c_req && hb == cb && mode_q[hb] == M_DATA |-> !h_ready);
endmodule

bind srm_arbiter srm_checker #(.NBLK(NBLK), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .mode_q     (mode_q),
    .h_req      (h_req),
    .h_addr     (h_addr),
    .h_ready    (h_ready),
    .h_viol     (h_viol),
    .h_rdata    (h_rdata),
    .c_req      (c_req),
    .c_addr     (c_addr),
    .f_req      (f_req),
    .f_addr     (f_addr),
    .f_valid    (f_valid),
    .f_misalign (f_misalign),
    .d_req      (d_req),
    .d_addr     (d_addr),
    .d_ready    (d_ready)
);

// File: tb/tb_srm_arbiter.sv
module tb_srm_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [6:0]  cfg_wdata;
    logic        h_req, h_we, h_fetch;
    logic [3:0]  h_addr;
    logic [15:0] h_wdata;
    logic        h_ready, h_viol;
    logic [15:0] h_rdata;
    logic        c_req, c_we;
    logic [3:0]  c_addr;
    logic [15:0] c_wdata, c_rdata;
    logic        f_req;
    logic [2:0]  f_addr;
    logic        f_valid, f_misalign;
    logic [31:0] f_rdata;
    logic        d_req, d_we;
    logic [3:0]  d_addr;
    logic [15:0] d_wdata;
    logic        d_ready;
    logic [15:0] d_rdata;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] m [16];

    always #5 clk = ~clk;

    srm_arbiter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .h_req(h_req), .h_we(h_we), .h_fetch(h_fetch), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata), .h_viol(h_viol),
        .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .f_req(f_req), .f_addr(f_addr), .f_valid(f_valid),
        .f_misalign(f_misalign), .f_rdata(f_rdata), .d_req(d_req), .d_we(d_we),
        .d_addr(d_addr), .d_wdata(d_wdata), .d_ready(d_ready), .d_rdata(d_rdata)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic clr();
        cfg_we = 0; cfg_wdata = '0;
        h_req = 0; h_we = 0; h_fetch = 0; h_addr = '0; h_wdata = '0;
        c_req = 0; c_we = 0; c_addr = '0; c_wdata = '0;
        f_req = 0; f_addr = '0;
        d_req = 0; d_we = 0; d_addr = '0; d_wdata = '0;
    endtask

    task automatic host(input logic we, input logic fe, input logic [3:0] a, input logic [15:0] wd);
        h_req = 1; h_we = we; h_fetch = fe; h_addr = a; h_wdata = wd;
    endtask

    task automatic cop(input logic we, input logic [3:0] a, input logic [15:0] wd);
        c_req = 1; c_we = we; c_addr = a; c_wdata = wd;
    endtask

    task automatic dbg(input logic we, input logic [3:0] a, input logic [15:0] wd);
        d_req = 1; d_we = we; d_addr = a; d_wdata = wd;
    endtask

    task automatic next();
        @(negedge clk);
        clr();
    endtask

    task automatic set_cfg(input logic [6:0] v);
        cfg_we = 1; cfg_wdata = v;
        next();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #1500000;
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        clr();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 reset ready", h_ready, 1);
        chk("R1 reset viol", h_viol, 0);
        chk("R5 reset fetch", f_valid, 0);
        next();

        // R1: free host access to every address
        for (int a = 0; a < 16; a++) begin
            host(1, 0, 4'(a), 16'(a * 37 + 5));
            #1 chk("R1 write ready", {h_ready, h_viol}, 2'b10);
            m[a] = 16'(a * 37 + 5);
            next();
        end
        for (int a = 0; a < 16; a++) begin
            host(0, 0, 4'(a), 0);
            #1 chk("R1 read", h_rdata, m[a]);
            next();
        end
        host(0, 1, 4'd5, 0);
        #1 chk("R1 fetch read", h_rdata, m[5]);
        next();

        // R9: coprocessor refused on host-mode banks
        cop(1, 4'd3, 16'hdead);
        #1 chk("R9 cop rdata", c_rdata, 0);
        next();
        cop(0, 4'd9, 0);
        #1 chk("R9 cop rdata b1", c_rdata, 0);
        next();
        host(0, 0, 4'd3, 0);
        #1 chk("R9 cop write dropped", h_rdata, m[3]);
        next();

        // R10: debug yields to host on same bank
        host(0, 0, 4'd9, 0); dbg(0, 4'd10, 0);
        #1 chk("R10 dbg blocked", d_ready, 0);
        next();
        host(0, 0, 4'd1, 0); dbg(1, 4'd10, 16'h1234);
        #1 chk("R10 dbg granted", d_ready, 1);
        m[10] = 16'h1234;
        next();
        dbg(0, 4'd10, 0);
        #1 chk("R10 dbg readback", d_rdata, m[10]);
        next();

        // R3: access in cfg cycle uses old mapping
        cfg_we = 1; cfg_wdata = 7'h01;
        host(1, 0, 4'd2, 16'hbeef);
        #1 chk("R3 old mapping", {h_ready, h_viol}, 2'b10);
        m[2] = 16'hbeef;
        next();
        host(1, 0, 4'd2, 16'h0bad);
        #1 chk("R6 write refused", {h_ready, h_viol}, 2'b11);
        next();
        host(0, 0, 4'd2, 0);
        #1 chk("R6 read zero", {h_viol, h_rdata}, {1'b1, 16'h0});
        next();

        // R5 + R4: fetch sweep with colliding debug
        for (int a = 0; a < 8; a++) begin
            f_req = 1; f_addr = 3'(a); dbg(0, 4'(a), 0);
            #1;
            if (a % 2 == 0)
                chk("R5 even fetch", {f_valid, f_misalign, f_rdata}, {2'b10, m[a+1], m[a]});
            else
                chk("R5 odd fetch", {f_valid, f_misalign, f_rdata}, {2'b01, 32'h0});
            chk("R4 dbg during fetch", d_ready, 0);
            next();
        end
        dbg(0, 4'd4, 0);
        #1 chk("R4 dbg free read", {d_ready, d_rdata}, {1'b1, m[4]});
        next();
        dbg(1, 4'd6, 16'h5a5a);
        #1 chk("R4 dbg free write", d_ready, 1);
        m[6] = 16'h5a5a;
        next();
        f_req = 1; f_addr = 3'd6;
        #1 chk("R4 dbg write fetched", f_rdata, {m[7], m[6]});
        next();

        // R2: bank 1 to data mode, bank 0 back to host
        set_cfg(7'h04);
        host(0, 0, 4'd2, 0);
        #1 chk("R6 dropped write kept old", h_rdata, m[2]);
        next();
        f_req = 1; f_addr = 3'd0;
        #1 chk("R5 fetch not prog", {f_valid, f_misalign}, 2'b00);
        next();

        // R7: conflict sweep on bank 1
        for (int a = 0; a < 8; a++) begin
            cop(1, 4'(8 + a), 16'(a * 11 + 300));
            host(1, 0, 4'(8 + a), 16'hffff);
            #1 chk("R7 host stalled", h_ready, 0);
            m[8 + a] = 16'(a * 11 + 300);
            next();
            host(0, 0, 4'(8 + a), 0);
            #1 chk("R7 cop won", {h_ready, h_rdata}, {1'b1, m[8 + a]});
            next();
        end
        host(0, 0, 4'd0, 0); cop(0, 4'd9, 0);
        #1 chk("R7 no conflict", {h_ready, h_rdata, c_rdata}, {1'b1, m[0], m[9]});
        next();

        // R8: fetch protection alone
        set_cfg(7'h14);
        host(0, 1, 4'd9, 0);
        #1 chk("R8 fetch blocked", {h_viol, h_rdata}, {1'b1, 16'h0});
        next();
        host(0, 0, 4'd9, 0);
        #1 chk("R8 read allowed", {h_viol, h_rdata}, {1'b0, m[9]});
        next();
        host(1, 0, 4'd9, 16'h7777);
        #1 chk("R8 write allowed", h_viol, 0);
        m[9] = 16'h7777;
        next();
        // R8: write protection alone
        set_cfg(7'h44);
        host(1, 0, 4'd9, 16'h1111);
        #1 chk("R8 write blocked", h_viol, 1);
        next();
        host(0, 1, 4'd9, 0);
        #1 chk("R8 fetch allowed", {h_viol, h_rdata}, {1'b0, m[9]});
        next();

        // R2: program precedence on bank 0, bank 1 back to host
        set_cfg(7'h03);
        host(0, 0, 4'd0, 0);
        #1 chk("R2 prog precedence", h_viol, 1);
        next();
        cop(0, 4'd9, 0);
        #1 chk("R2 bank1 host again", c_rdata, 0);
        next();

        // R10: debug in data mode
        set_cfg(7'h04);
        cop(0, 4'd8, 0); dbg(0, 4'd9, 0);
        #1 chk("R10 dbg vs cop", d_ready, 0);
        next();
        cop(0, 4'd0, 0); dbg(0, 4'd9, 0);
        #1 chk("R10 dbg other bank", {d_ready, d_rdata}, {1'b1, m[9]});
        next();

        summary();
    end
endmodule